// File: doc/BRIEF.md
# SPI Register Access Slave

This block is an SPI slave that lets an external master read and write a small bank of byte-wide registers. Each frame opens when slave select falls. The first byte of the frame is a command byte. It carries a start address and an access mode. Every complete byte after it either writes the register at the current address or is answered on MISO with that register's contents. The address steps by one after each data byte, so a single frame can move a burst of bytes.

Address 0 holds a configuration byte. One of its bits opens the user register window. The window is a run of consecutive registers that starts at address 0x20. A third access mode, fetch, makes the block raise a one-cycle pulse in the system clock domain after slave select returns high. Local logic can use that pulse to act on the registers. Local logic reads the user registers through a registered index/data port in the system clock domain.

The shifter, command decode and register bank run on the serial clock. Only slave select is carried into the system clock, through a synchronizer chain, and the fetch pulse is formed there.

Top module: `spi_rab_top`

## Requirements
- R1: SPI mode 0 is used. MOSI is sampled on the rising edge of SCLK and MISO changes on the falling edge, most significant bit first. The first byte after slave select falls is the command: bits [5:0] give the start address and bits [7:6] give the mode.
- R2: Mode 00 writes each complete data byte to the current address. Mode 10 returns register contents on MISO. Mode 11 (fetch) and mode 01 perform no writes and return zeros. Mode 01 has no other effect.
- R3: The address advances by one after every data byte and wraps from 0x3F to 0x00.
- R4: Address 0x00 is the configuration register, with reset value 0x00. While its bit 5 is clear, writes to user registers are ignored and user registers read as 0x00.
- R5: Thirteen user registers at addresses 0x20 to 0x2C are readable and writable. Every other address except 0x00 reads 0x00 and ignores writes.
- R6: In a read frame MISO is 0 during the command byte. Data byte k (counting from 0) carries the register at the start address plus k.
- R7: When slave select rises after a frame whose mode was fetch, fetch_o goes high for exactly one system clock cycle, within six cycles. Frames of any other mode produce no pulse.
- R8: A frame carries at most 12 data bytes. Data bytes beyond the twelfth write nothing and read as 0x00.
- R9: A final byte with fewer than eight bits is discarded and writes nothing.
- R10: loc_data_o gives user register loc_idx_i (0 = address 0x20) one system clock cycle after the index is applied. Indices of 13 or more read 0x00.
- R11: After reset, fetch_o is 0 and MISO is 0 while slave select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Active-high reset |
| sclk_i | input | 1 | Serial clock from the master, idle low |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| fetch_o | output | 1 | One-cycle fetch pulse, system clock domain |
| loc_idx_i | input | 4 | Local read index into the user registers |
| loc_data_o | output | 8 | Registered local read data |

## Verification
The bench targets the edges of a burst. It covers a thirteenth data byte, which a design without a byte limit would write into 0x2C. It covers a truncated last byte, which a design that commits on slave select would write as a partial value. It covers an address that wraps past 0x3F into the configuration register, which a design with a wider counter would miss. It checks that a read is held to zero during the command byte, since a design that loads MISO one byte early shifts every returned value. It also writes with the enable bit cleared, uses the reserved mode, and addresses a location outside the window. It confirms that the fetch pulse is exactly one cycle wide and that a read frame produces no pulse.

// File: rtl/spi_rab_pkg.sv
package spi_rab_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'b00,
    MODE_RSVD  = 2'b01,
    MODE_READ  = 2'b10,
    MODE_FETCH = 2'b11
  } mode_e;

  localparam int CFG_USER_EN_BIT = 5;

endpackage

// File: rtl/spi_rab_shifter.sv
module spi_rab_shifter
  import spi_rab_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 6,
  parameter int MAX_DATA = 12
) (
  input  logic              rst_i,
  input  logic              sclk_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] cmd_o,
  output mode_e             mode_o
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(MAX_DATA + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_DATA);

  logic [BIT_W-1:0]  bit_cnt_q;
  logic              first_q;
  logic [CNT_W-1:0]  data_cnt_q;
  logic [DATA_W-2:0] rx_sh_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic [DATA_W-1:0] cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] full_byte;
  logic              byte_done;
  logic              in_limit;
  mode_e             mode_w;

  assign full_byte = {rx_sh_q, mosi_i};
  assign byte_done = (bit_cnt_q == LAST_BIT);
  assign in_limit  = (data_cnt_q != CNT_MAX);
  assign mode_w    = mode_e'(cmd_q[DATA_W-1 -: 2]);

  // frame state, cleared while slave select is high
  always_ff @(posedge sclk_i or posedge ss_n_i) begin
    if (ss_n_i) begin
      bit_cnt_q  <= '0;
      first_q    <= 1'b1;
      data_cnt_q <= '0;
      rx_sh_q    <= '0;
    end else begin
      bit_cnt_q <= bit_cnt_q + 1'b1;
      rx_sh_q   <= full_byte[DATA_W-2:0];
      if (byte_done) begin
        first_q <= 1'b0;
        if (!first_q && in_limit) data_cnt_q <= data_cnt_q + 1'b1;
      end
    end
  end

  // command and address survive the end of the frame
  always_ff @(posedge sclk_i or posedge rst_i) begin
    if (rst_i) begin
      cmd_q  <= '0;
      addr_q <= '0;
    end else if (!ss_n_i && byte_done) begin
      if (first_q) begin
        cmd_q  <= full_byte;
        addr_q <= full_byte[ADDR_W-1:0];
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  // MISO shifter on the falling edge
  always_ff @(negedge sclk_i or posedge ss_n_i) begin
    if (ss_n_i) begin
      tx_sh_q <= '0;
    end else if (bit_cnt_q == '0 && !first_q) begin
      tx_sh_q <= (mode_w == MODE_READ && in_limit) ? rd_data_i : '0;
    end else begin
      tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign miso_o    = !ss_n_i && tx_sh_q[DATA_W-1];
  assign wr_en_o   = !ss_n_i && byte_done && !first_q && in_limit && (mode_w == MODE_WRITE);
  assign addr_o    = addr_q;
  assign wr_data_o = full_byte;
  assign cmd_o     = cmd_q;
  assign mode_o    = mode_w;

endmodule

// File: rtl/spi_rab_regbank.sv
module spi_rab_regbank
  import spi_rab_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int USER_BASE = 32,
  parameter int USER_NUM  = 13,
  parameter int LOC_W     = 4
) (
  input  logic              rst_i,
  input  logic              clk_i,
  input  logic              sclk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [LOC_W-1:0]  loc_idx_i,
  output logic [DATA_W-1:0] loc_data_o
);

  localparam int IDX_W = (USER_NUM > 1) ? $clog2(USER_NUM) : 1;

  logic [DATA_W-1:0] mem [USER_NUM];
  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] loc_q;
  logic              is_cfg;
  logic              is_user;
  logic              user_en;
  logic [IDX_W-1:0]  idx;

  assign is_cfg  = (addr_i == '0);
  assign is_user = (int'(addr_i) >= USER_BASE) && (int'(addr_i) < USER_BASE + USER_NUM);
  assign user_en = cfg_q[CFG_USER_EN_BIT];
  assign idx     = IDX_W'(int'(addr_i) - USER_BASE);

  always_ff @(posedge sclk_i or posedge rst_i) begin
    if (rst_i)                  cfg_q <= '0;
    else if (wr_en_i && is_cfg) cfg_q <= wr_data_i;
  end

  // user storage, no reset so it maps onto RAM
  always_ff @(posedge sclk_i) begin
    if (wr_en_i && is_user && user_en) mem[idx] <= wr_data_i;
  end

  always_comb begin
    if (is_cfg)                  rd_data_o = cfg_q;
    else if (is_user && user_en) rd_data_o = mem[idx];
    else                         rd_data_o = '0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                          loc_q <= '0;
    else if (int'(loc_idx_i) < USER_NUM) loc_q <= mem[IDX_W'(loc_idx_i)];
    else                                loc_q <= '0;
  end

  assign loc_data_o = loc_q;

endmodule

// File: rtl/spi_rab_ssync.sv
module spi_rab_ssync
  import spi_rab_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  ss_n_i,
  input  mode_e mode_i,
  output logic  fetch_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              fetch_q;
  logic              rise;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '1;
        else       sync_q <= ss_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '1;
        else       sync_q <= {sync_q[STAGES-2:0], ss_n_i};
      end
    end
  endgenerate

  assign rise = sync_q[STAGES-1] && !prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q  <= 1'b1;
      fetch_q <= 1'b0;
    end else begin
      prev_q  <= sync_q[STAGES-1];
      fetch_q <= rise && (mode_i == MODE_FETCH);
    end
  end

  assign fetch_o = fetch_q;

endmodule

// File: rtl/spi_rab_top.sv
module spi_rab_top
  import spi_rab_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 6,
  parameter int USER_BASE   = 32,
  parameter int USER_NUM    = 13,
  parameter int MAX_DATA    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int LOC_W       = $clog2(USER_NUM)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sclk_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              fetch_o,
  input  logic [LOC_W-1:0]  loc_idx_i,
  output logic [DATA_W-1:0] loc_data_o
);

  logic              wr_en_w;
  logic [ADDR_W-1:0] addr_w;
  logic [DATA_W-1:0] wr_data_w;
  logic [DATA_W-1:0] rd_data_w;
  logic [DATA_W-1:0] cmd_byte_w;
  mode_e             cmd_mode_w;

  spi_rab_shifter #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .MAX_DATA(MAX_DATA)
  ) u_shift (
    .rst_i    (rst_i),
    .sclk_i   (sclk_i),
    .ss_n_i   (ss_n_i),
    .mosi_i   (mosi_i),
    .miso_o   (miso_o),
    .wr_en_o  (wr_en_w),
    .addr_o   (addr_w),
    .wr_data_o(wr_data_w),
    .rd_data_i(rd_data_w),
    .cmd_o    (cmd_byte_w),
    .mode_o   (cmd_mode_w)
  );

  spi_rab_regbank #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .USER_BASE(USER_BASE),
    .USER_NUM (USER_NUM),
    .LOC_W    (LOC_W)
  ) u_bank (
    .rst_i     (rst_i),
    .clk_i     (clk_i),
    .sclk_i    (sclk_i),
    .wr_en_i   (wr_en_w),
    .addr_i    (addr_w),
    .wr_data_i (wr_data_w),
    .rd_data_o (rd_data_w),
    .loc_idx_i (loc_idx_i),
    .loc_data_o(loc_data_o)
  );

  spi_rab_ssync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .ss_n_i (ss_n_i),
    .mode_i (cmd_mode_w),
    .fetch_o(fetch_o)
  );

endmodule

// File: rtl/spi_rab_chk.sv
module spi_rab_chk
  import spi_rab_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int USER_NUM = 13,
  parameter int LOC_W    = 4
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              ss_n_i,
  input logic              fetch_o,
  input logic [LOC_W-1:0]  loc_idx_i,
  input logic [DATA_W-1:0] loc_data_o,
  input logic [DATA_W-1:0] cmd_byte_w,
  input mode_e             cmd_mode_w
);

  AST_FETCH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    fetch_o |=> !fetch_o); // R7

  AST_FETCH_MODE_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
    fetch_o |-> (cmd_mode_w == MODE_FETCH)); // R7

  AST_FETCH_SS_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    fetch_o |-> ss_n_i); // R7

  AST_CMD_HELD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (ss_n_i && $past(ss_n_i)) |-> $stable(cmd_byte_w)); // R1

  AST_LOCAL_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (int'($past(loc_idx_i)) >= USER_NUM) |-> (loc_data_o == '0)); // R10

endmodule

bind spi_rab_top spi_rab_chk #(
  .DATA_W  (DATA_W),
  .USER_NUM(USER_NUM),
  .LOC_W   (LOC_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .ss_n_i    (ss_n_i),
  .fetch_o   (fetch_o),
  .loc_idx_i (loc_idx_i),
  .loc_data_o(loc_data_o),
  .cmd_byte_w(cmd_byte_w),
  .cmd_mode_w(cmd_mode_w)
);

// File: tb/spi_rab_top_tb.sv
`timescale 1ns/1ps
module spi_rab_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       ss_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic       fetch;
  logic [3:0] loc_idx = 4'd0;
  logic [7:0] loc_data;

  int checks = 0;
  int errors = 0;
  int fetch_cnt = 0;
  logic [7:0] tx_buf [0:15];
  logic [7:0] rx_buf [0:15];

  always #2 clk = ~clk;

  spi_rab_top dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .sclk_i    (sclk),
    .ss_n_i    (ss_n),
    .mosi_i    (mosi),
    .miso_o    (miso),
    .fetch_o   (fetch),
    .loc_idx_i (loc_idx),
    .loc_data_o(loc_data)
  );

  always @(negedge clk) if (fetch) fetch_cnt++;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // frame of 1 command byte + nbytes data bytes + extra trailing bits
  task automatic spi_frame(input int nbytes, input int extra);
    ss_n = 1'b0;
    #10;
    for (int i = 0; i <= nbytes; i++) begin
      for (int b = 7; b >= 0; b--) begin
        mosi = tx_buf[i][b];
        #10;
        rx_buf[i][b] = miso;
        sclk = 1'b1;
        #10;
        sclk = 1'b0;
      end
    end
    for (int b = 7; b > 7 - extra; b--) begin
      mosi = tx_buf[nbytes + 1][b];
      #10;
      sclk = 1'b1;
      #10;
      sclk = 1'b0;
    end
    #10;
    ss_n = 1'b1;
    #60;
  endtask

  task automatic wr1(input logic [5:0] addr, input logic [7:0] data);
    tx_buf[0] = {2'b00, addr};
    tx_buf[1] = data;
    spi_frame(1, 0);
  endtask

  task automatic rd1(input logic [5:0] addr, output logic [7:0] data);
    tx_buf[0] = {2'b10, addr};
    tx_buf[1] = 8'h00;
    spi_frame(1, 0);
    data = rx_buf[1];
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check8("R11 fetch idle", {7'd0, fetch}, 8'h00);
    check8("R11 miso idle", {7'd0, miso}, 8'h00);
    rd1(6'h00, v);
    check8("R11/R4 cfg reset value", v, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    wr1(6'h00, 8'h20);
    rd1(6'h00, v);
    check8("R4 cfg readback", v, 8'h20);
    check8("R6 miso zero in command byte", rx_buf[0], 8'h00);
  endtask

  task automatic t_single();
    logic [7:0] v;
    for (int j = 0; j < 13; j++) wr1(6'(32 + j), 8'(255 - 2 * j));
    for (int j = 0; j < 13; j++) begin
      rd1(6'(32 + j), v);
      check8("R1/R5 single register", v, 8'(255 - 2 * j));
    end
  endtask

  task automatic t_burst();
    logic [7:0] pat [0:6];
    logic [7:0] v;
    pat = '{8'hFE, 8'hDC, 8'hBA, 8'h98, 8'h76, 8'h54, 8'h32};
    tx_buf[0] = 8'h20;
    for (int k = 0; k < 7; k++) tx_buf[k + 1] = pat[k];
    spi_frame(7, 0);
    tx_buf[0] = 8'hA0;
    for (int k = 0; k < 7; k++) tx_buf[k + 1] = 8'h00;
    spi_frame(7, 0);
    check8("R6 burst command byte zero", rx_buf[0], 8'h00);
    for (int k = 0; k < 7; k++) check8("R3/R6 burst data", rx_buf[k + 1], pat[k]);
    rd1(6'h27, v);
    check8("R3 burst stops at length", v, 8'hF1);
  endtask

  task automatic t_max();
    logic [7:0] v;
    tx_buf[0] = 8'h20;
    for (int k = 0; k < 13; k++) tx_buf[k + 1] = 8'(16 + k);
    spi_frame(13, 0);
    rd1(6'h2C, v);
    check8("R8 thirteenth byte not written", v, 8'hE7);
    tx_buf[0] = 8'hA0;
    for (int k = 0; k < 13; k++) tx_buf[k + 1] = 8'h00;
    spi_frame(13, 0);
    for (int k = 0; k < 12; k++) check8("R8 full burst read", rx_buf[k + 1], 8'(16 + k));
    check8("R8 thirteenth byte reads zero", rx_buf[13], 8'h00);
  endtask

  task automatic t_partial();
    logic [7:0] v;
    tx_buf[0] = 8'h21;
    tx_buf[1] = 8'h5A;
    tx_buf[2] = 8'hC3;
    spi_frame(1, 5);
    rd1(6'h21, v);
    check8("R9 complete byte written", v, 8'h5A);
    rd1(6'h22, v);
    check8("R9 partial byte dropped", v, 8'h12);
  endtask

  task automatic t_gate();
    logic [7:0] v;
    wr1(6'h00, 8'h00);
    wr1(6'h20, 8'h99);
    rd1(6'h20, v);
    check8("R4 disabled read zero", v, 8'h00);
    wr1(6'h00, 8'h20);
    rd1(6'h20, v);
    check8("R4 disabled write ignored", v, 8'h10);
  endtask

  task automatic t_rsvd();
    logic [7:0] v;
    tx_buf[0] = 8'h63;
    tx_buf[1] = 8'h44;
    spi_frame(1, 0);
    check8("R2 reserved mode miso zero", rx_buf[1], 8'h00);
    rd1(6'h23, v);
    check8("R2 reserved mode no write", v, 8'h13);
  endtask

  task automatic t_other();
    logic [7:0] v;
    wr1(6'h10, 8'h77);
    rd1(6'h10, v);
    check8("R5 unmapped address", v, 8'h00);
  endtask

  task automatic t_wrap();
    tx_buf[0] = 8'hBF;
    tx_buf[1] = 8'h00;
    tx_buf[2] = 8'h00;
    spi_frame(2, 0);
    check8("R3 top address reads zero", rx_buf[1], 8'h00);
    check8("R3 wrap to cfg", rx_buf[2], 8'h20);
  endtask

  task automatic t_fetch();
    logic [7:0] v;
    fetch_cnt = 0;
    tx_buf[0] = 8'hE0;
    spi_frame(0, 0);
    check8("R7 fetch pulse count", 8'(fetch_cnt), 8'h01);
    fetch_cnt = 0;
    rd1(6'h20, v);
    check8("R7 no pulse on read", 8'(fetch_cnt), 8'h00);
  endtask

  task automatic t_local();
    loc_idx = 4'd0;
    @(posedge clk); @(posedge clk); #1;
    check8("R10 local index 0", loc_data, 8'h10);
    loc_idx = 4'd12;
    @(posedge clk); @(posedge clk); #1;
    check8("R10 local index 12", loc_data, 8'hE7);
    loc_idx = 4'd15;
    @(posedge clk); @(posedge clk); #1;
    check8("R10 local out of range", loc_data, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      tx_buf[i] = 8'h00;
      rx_buf[i] = 8'h00;
    end
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_enable();
    t_single();
    t_burst();
    t_max();
    t_partial();
    t_gate();
    t_rsvd();
    t_other();
    t_wrap();
    t_fetch();
    t_local();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule